// File: doc/BRIEF.md
# Streaming Ungapped Local Alignment Scorer

This block scores a short stored query sequence against a long database sequence that arrives one 2-bit character at a time. The most recent N database characters sit in a shift window lined up position by position against the query. Each position gives a match score. A pipelined tree of segment-merge nodes then reduces the score vector to the largest sum over any contiguous run of positions. That sum is the best ungapped local alignment of the query at the current database offset.

The query is written one character at a time through a small write port, while the stream is idle. After that the database is pushed in with a valid strobe, and no stall or random access is ever needed. Once the window is full, every accepted character yields exactly one result. Results leave the block at the streaming rate after a fixed pipeline delay. Gaps between valid characters are passed through as gaps in the result stream.

Top module: `align_scorer`

## Requirements
- R1: After reset, `out_valid` is low and every query position holds character 0, so a stream of N zero characters scores 2N without any query write.
- R2: A cycle with `q_we` high stores `q_data` at query position `q_addr`, and that value is used for every window scored after the write.
- R3: The window holds the last N accepted characters: the oldest is compared with query position 0 and the newest with position N-1. A cycle with `db_valid` low leaves the window unchanged.
- R4: A position scores +2 when its query and window characters are equal and -1 when they differ.
- R5: `out_best` is the largest sum of scores over any contiguous run of positions, taken as 0 when no run has a positive sum.
- R6: `out_valid` is high exactly log2(N)+2 cycles after each clock edge that accepts a character with the window full after that edge, and low in every other cycle.
- R7: A window with no equal position reports 0, and a window equal at every position reports 2N.
- R8: No result is produced until N characters have been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| q_we | input | 1 | Query write strobe |
| q_addr | input | log2(N) | Query position to write |
| q_data | input | CW | Query character to write |
| db_valid | input | 1 | Database character present this cycle |
| db_char | input | CW | Database character |
| out_valid | output | 1 | Result present this cycle |
| out_best | output | log2(2N+1) | Best local segment score |

## Verification
A wrong internal state shows as a wrong `out_best` or a misplaced `out_valid` log2(N)+2 cycles after the character that caused it. So the bench compares every output cycle, valid or not, against a schedule it builds from its own window model. A window slip or a query misfile shows up within one result as a score that does not match the bench's own run search. A merge error in one tree node appears only for score vectors whose best run crosses that node's boundary. For this reason the random streams are mixed with directed patterns: alternating matches, isolated mismatches, and all-equal and all-different windows.

// File: rtl/align_scorer.sv
module align_scorer #(
  parameter int N  = 8,
  parameter int CW = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           q_we,
  input  logic [$clog2(N)-1:0]           q_addr,
  input  logic [CW-1:0]                  q_data,
  input  logic                           db_valid,
  input  logic [CW-1:0]                  db_char,
  output logic                           out_valid,
  output logic [$clog2(2*N+1)-1:0]       out_best
);
  localparam int L  = $clog2(N);
  localparam int FW = $clog2(N+1);
  localparam int SW = $clog2(2*N+1) + 2;
  localparam int BW = $clog2(2*N+1);
  localparam logic signed [SW-1:0] SC_HIT  = SW'(2);
  localparam logic signed [SW-1:0] SC_MISS = -SW'(1);

  function automatic logic signed [SW-1:0] mx(input logic signed [SW-1:0] a,
                                             input logic signed [SW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0] qry [N];
  logic [CW-1:0] win [N];
  logic [FW-1:0] fill;
  logic          acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) qry[i] <= '0;
    end else if (q_we) begin
      qry[q_addr] <= q_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill  <= '0;
      acc_q <= 1'b0;
      for (int i = 0; i < N; i++) win[i] <= '0;
    end else begin
      acc_q <= db_valid && (int'(fill) >= N - 1);
      if (db_valid) begin
        for (int i = 0; i < N - 1; i++) win[i] <= win[i+1];
        win[N-1] <= db_char;
        if (int'(fill) != N) fill <= fill + FW'(1);
      end
    end
  end

  for (genvar k = 0; k <= L; k++) begin : lv
    localparam int M = N >> k;
    logic signed [SW-1:0] t [M];
    logic signed [SW-1:0] p [M];
    logic signed [SW-1:0] s [M];
    logic signed [SW-1:0] b [M];
    logic                 v;

    if (k == 0) begin : lf
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= acc_q;
        for (int j = 0; j < M; j++) begin
          t[j] <= (qry[j] == win[j]) ? SC_HIT : SC_MISS;
          p[j] <= (qry[j] == win[j]) ? SC_HIT : '0;
          s[j] <= (qry[j] == win[j]) ? SC_HIT : '0;
          b[j] <= (qry[j] == win[j]) ? SC_HIT : '0;
        end
      end
    end else begin : nd
      always_ff @(posedge clk) begin
        if (!rst_n) v <= 1'b0;
        else        v <= lv[k-1].v;
        for (int j = 0; j < M; j++) begin
          t[j] <= lv[k-1].t[2*j] + lv[k-1].t[2*j+1];
          p[j] <= mx(lv[k-1].p[2*j], lv[k-1].t[2*j] + lv[k-1].p[2*j+1]);
          s[j] <= mx(lv[k-1].s[2*j+1], lv[k-1].t[2*j+1] + lv[k-1].s[2*j]);
          b[j] <= mx(mx(lv[k-1].b[2*j], lv[k-1].b[2*j+1]),
                     lv[k-1].s[2*j] + lv[k-1].p[2*j+1]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_best  <= '0;
    end else begin
      out_valid <= lv[L].v;
      out_best  <= BW'(lv[L].b[0]);
    end
  end

  p_fill_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= N);

  p_no_early_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(fill) == N);

  p_root_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lv[L].v |-> (lv[L].b[0] >= lv[L].p[0] && lv[L].b[0] >= lv[L].s[0] && lv[L].p[0] >= 0));

  p_best_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_best) <= 2 * N);

  p_total_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lv[L].v |-> (lv[L].t[0] >= -N && lv[L].t[0] <= 2 * N));
endmodule

// File: tb/tb_align_scorer.sv
`timescale 1ns/1ps
module tb_align_scorer;
  localparam int N = 8;
  localparam int L = 3;
  localparam int LAT = L + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_we = 1'b0;
  logic [2:0] q_addr = '0;
  logic [1:0] q_data = '0;
  logic db_valid = 1'b0;
  logic [1:0] db_char = '0;
  logic out_valid;
  logic [4:0] out_best;

  align_scorer #(.N(N), .CW(2)) dut (
    .clk(clk), .rst_n(rst_n), .q_we(q_we), .q_addr(q_addr), .q_data(q_data),
    .db_valid(db_valid), .db_char(db_char), .out_valid(out_valid), .out_best(out_best));

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit running = 0, done = 0;
  logic [1:0] qm [N];
  logic [1:0] wm [N];
  int fillm = 0;
  bit ev [16];
  int eb [16];
  string et [16];
  string tag = "R6";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int best_run();
    int cur = 0, bst = 0;
    for (int i = 0; i < N; i++) begin
      cur = cur + ((qm[i] == wm[i]) ? 2 : -1);
      if (cur < 0) cur = 0;
      if (cur > bst) bst = cur;
    end
    return bst;
  endfunction

  task automatic send(input bit v, input logic [1:0] c);
    @(negedge clk);
    db_valid = v;
    db_char = c;
    if (v) begin
      for (int i = 0; i < N - 1; i++) wm[i] = wm[i+1];
      wm[N-1] = c;
      if (fillm < N) fillm++;
      if (fillm == N) begin
        ev[(cyc + LAT) % 16] = 1;
        eb[(cyc + LAT) % 16] = best_run();
        et[(cyc + LAT) % 16] = tag;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 2'd0);
  endtask

  task automatic wq(input int a, input logic [1:0] c);
    @(negedge clk);
    q_we = 1; q_addr = 3'(a); q_data = c; qm[a] = c;
    @(negedge clk);
    q_we = 0;
  endtask

  always @(negedge clk) begin
    if (running) begin
      int sl;
      sl = cyc % 16;
      tests++;
      if (out_valid !== ev[sl]) begin
        fails++;
        $display("FAIL %s/R6 cycle %0d out_valid actual %0b expected %0b", et[sl], cyc, out_valid, ev[sl]);
      end else if (ev[sl]) begin
        tests++;
        if (int'(out_best) != eb[sl]) begin
          fails++;
          $display("FAIL %s/R5 cycle %0d out_best actual %0d expected %0d", et[sl], cyc, out_best, eb[sl]);
        end
      end
      ev[sl] = 0;
      et[sl] = "R6";
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin ev[i] = 0; eb[i] = 0; et[i] = "R6"; end
    for (int i = 0; i < N; i++) begin qm[i] = 0; wm[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid after reset actual %0b expected 0", out_valid);
    end
    running = 1;

    tag = "R8";
    for (int i = 0; i < N - 1; i++) send(1, 2'd0);
    idle(LAT + 2);
    tag = "R1";
    send(1, 2'd0);
    idle(LAT + 2);

    tag = "R2";
    for (int i = 0; i < N; i++) wq(i, 2'($urandom_range(3)));
    for (int i = 0; i < 40; i++) send(1, 2'($urandom_range(3)));
    idle(LAT + 2);

    tag = "R3";
    for (int i = 0; i < 300; i++) send($urandom_range(3) != 0, 2'($urandom_range(3)));
    idle(LAT + 2);

    tag = "R7";
    for (int i = 0; i < N; i++) wq(i, 2'd1);
    for (int i = 0; i < N; i++) send(1, 2'd2);
    for (int i = 0; i < N; i++) send(1, 2'd1);
    idle(LAT + 2);

    tag = "R4";
    for (int i = 0; i < N; i++) wq(i, 2'(i % 2));
    for (int i = 0; i < 2 * N; i++) send(1, 2'd0);
    for (int i = 0; i < N; i++) send(1, (i == 3) ? 2'd3 : 2'(i % 2));
    idle(LAT + 2);

    tag = "R5";
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < N; i++) wq(i, 2'($urandom_range(3)));
      for (int i = 0; i < 20; i++) send(1, ($urandom_range(4) == 0) ? 2'($urandom_range(3)) : qm[(i + 1) % N]);
      idle(LAT + 2);
    end

    done = 1;
    running = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule